// File: doc/BRIEF.md
# External Bus Strobe Generator

This block derives the two timing strobes of an 8051-style external bus from the oscillator clock. It splits each machine cycle of twelve oscillator periods into numbered slots. It raises the address-latch strobe at the start of each half-cycle. While code runs from external memory, it also pulls the active-low program read strobe low after each latch pulse.

The bus sequencer supplies four plain control levels: external execution, an external data-memory access in the current cycle, a data-move instruction in progress, and a latch-disable control bit. The block samples these once, on the clock edge that begins slot 0. The sampled values then govern the whole machine cycle. During a data-memory cycle the block omits the second latch pulse and both read-strobe pulses. When the disable bit is set, the latch strobe is confined to data-move instructions and otherwise rests high. External execution overrides the disable bit. The block has no data path, so there is no valid/ready interface; all pins are plain control and status levels.

Top module: `ext_strobe_gen`

## Requirements
- R1: The slot output counts 0,1,...,11 on successive clocks and wraps from 11 to 0; reset holds it at 0.
- R2: While reset is high the latch strobe is 0, the read strobe (active low) is 1, and the slot is 0.
- R3: In a cycle whose latch strobe is enabled and that has no data-memory access, the latch strobe is 1 in slots 0-1 and 6-7 and 0 in all other slots.
- R4: In a data-memory access cycle with the latch strobe enabled, the pulse in slots 0-1 stays and the pulse in slots 6-7 is omitted.
- R5: With external execution and no data-memory access, the read strobe is 0 in slots 2-4 and 8-10 and 1 in all other slots.
- R6: In a data-memory access cycle the read strobe stays 1 for the whole cycle.
- R7: Without external execution the read strobe stays 1.
- R8: With the disable bit 1, external execution 0 and data-move 0, the latch strobe is 1 throughout the cycle.
- R9: With the disable bit 1 and data-move 1, the latch strobe pulses as in R3 and R4.
- R10: With the disable bit 1 and external execution 1, the disable bit has no effect and the latch strobe pulses as in R3 and R4.
- R11: The four control inputs are sampled on the edge entering slot 0, and on every edge during reset. A change at any other edge has no effect until the next machine cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_exec_i | input | 1 | Code is fetched from external memory |
| data_cycle_i | input | 1 | This machine cycle accesses external data memory |
| move_instr_i | input | 1 | A data-move or code-move instruction is executing |
| latch_dis_i | input | 1 | Latch-strobe disable control bit |
| slot_o | output | 4 | Current oscillator slot within the machine cycle |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program read strobe, active low |

## Verification
The bench builds the block with its default parameters: twelve periods per machine cycle, a two-period latch pulse and a three-period read pulse. These values put every slot boundary within reach, including the wrap from 11 to 0 and the edges of the omitted second-half windows. Directed machine cycles cover each combination of control inputs that selects a distinct strobe pattern. Random phases change the inputs on every clock, so the bench can show that changes in the middle of a cycle wait for the next slot 0.

// File: rtl/strobe_gen_pkg.sv
package strobe_gen_pkg;
  typedef struct packed {
    logic ext;
    logic data;
    logic move;
    logic dis;
  } cyc_mode_t;
endpackage

// File: rtl/strobe_slot_counter.sv
module strobe_slot_counter #(
  parameter int PERIODS = 12,
  localparam int SW = $clog2(PERIODS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_o,
  output logic          last_o
);
  localparam logic [SW-1:0] LAST = SW'(PERIODS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst)                 slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o = slot_q;
  assign last_o = (slot_q == LAST);

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_q == LAST) |=> (slot_q == '0));

  // R1
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/strobe_mode_latch.sv
module strobe_mode_latch
  import strobe_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_i,
  input  cyc_mode_t mode_i,
  output cyc_mode_t mode_o
);
  cyc_mode_t mode_q;

  always_ff @(posedge clk) begin
    if (rst || load_i) mode_q <= mode_i;
  end

  assign mode_o = mode_q;

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(mode_q));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import strobe_gen_pkg::*;
#(
  parameter int PERIODS  = 12,
  parameter int LATCH_W  = 2,
  parameter int READ_W   = 3,
  localparam int SW      = $clog2(PERIODS),
  localparam int HALF    = PERIODS / 2
) (
  input  logic          rst,
  input  logic [SW-1:0] slot_i,
  input  cyc_mode_t     mode_i,
  output logic          ale_o,
  output logic          psen_n_o
);
  logic [1:0] ale_win;
  logic [1:0] rd_win;

  for (genvar k = 0; k < 2; k++) begin : g_half
    localparam logic [SW-1:0] A_LO = SW'(k * HALF);
    localparam logic [SW-1:0] A_HI = SW'(k * HALF + LATCH_W);
    localparam logic [SW-1:0] R_HI = SW'(k * HALF + LATCH_W + READ_W);
    assign ale_win[k] = (slot_i >= A_LO) && (slot_i < A_HI);
    assign rd_win[k]  = (slot_i >= A_HI) && (slot_i < R_HI);
  end

  logic latch_on;
  logic ale_pulse;
  logic rd_active;

  assign latch_on  = !mode_i.dis || mode_i.ext || mode_i.move;
  assign ale_pulse = ale_win[0] || (ale_win[1] && !mode_i.data);
  assign rd_active = mode_i.ext && !mode_i.data && (rd_win[0] || rd_win[1]);

  always_comb begin
    if (rst) begin
      ale_o    = 1'b0;
      psen_n_o = 1'b1;
    end else begin
      ale_o    = latch_on ? ale_pulse : 1'b1;
      psen_n_o = !rd_active;
    end
  end

  // R2
  always_comb begin
    if (rst) reset_idle_chk: assert (ale_o == 1'b0 && psen_n_o == 1'b1);
  end
endmodule

// File: rtl/ext_strobe_gen.sv
module ext_strobe_gen
  import strobe_gen_pkg::*;
#(
  parameter int PERIODS = 12,
  parameter int LATCH_W = 2,
  parameter int READ_W  = 3,
  localparam int SW     = $clog2(PERIODS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ext_exec_i,
  input  logic          data_cycle_i,
  input  logic          move_instr_i,
  input  logic          latch_dis_i,
  output logic [SW-1:0] slot_o,
  output logic          ale_o,
  output logic          psen_n_o
);
  logic      last;
  cyc_mode_t mode_in;
  cyc_mode_t mode;

  assign mode_in = '{ext: ext_exec_i, data: data_cycle_i,
                     move: move_instr_i, dis: latch_dis_i};

  strobe_slot_counter #(.PERIODS(PERIODS)) u_cnt (
    .clk(clk), .rst(rst), .slot_o(slot_o), .last_o(last)
  );

  strobe_mode_latch u_mode (
    .clk(clk), .rst(rst), .load_i(last), .mode_i(mode_in), .mode_o(mode)
  );

  strobe_decode #(.PERIODS(PERIODS), .LATCH_W(LATCH_W), .READ_W(READ_W)) u_dec (
    .rst(rst), .slot_i(slot_o), .mode_i(mode),
    .ale_o(ale_o), .psen_n_o(psen_n_o)
  );

  // R5
  no_strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n_o |-> !ale_o);

  // R6
  data_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    mode.data |-> psen_n_o);

  // R8
  latch_rest_high_chk: assert property (@(posedge clk) disable iff (rst)
    (mode.dis && !mode.ext && !mode.move) |-> ale_o);
endmodule

// File: tb/tb_ext_strobe_gen.sv
module tb_ext_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int N = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext = 1'b0, data = 1'b0, move = 1'b0, dis = 1'b0;
  logic [3:0] slot;
  logic ale, psen_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string phase = "";

  int   m_slot = 0;
  logic m_ext = 0, m_data = 0, m_move = 0, m_dis = 0;

  ext_strobe_gen dut (
    .clk(clk), .rst(rst), .ext_exec_i(ext), .data_cycle_i(data),
    .move_instr_i(move), .latch_dis_i(dis),
    .slot_o(slot), .ale_o(ale), .psen_n_o(psen_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of slot position and sampled controls (R1, R11)
  always @(posedge clk) begin
    if (rst || m_slot == N-1) begin
      m_slot = 0;
      m_ext = ext; m_data = data; m_move = move; m_dis = dis;
    end else begin
      m_slot = m_slot + 1;
    end
  end

  function automatic logic exp_ale();
    if (rst) return 1'b0;
    if (m_dis && !m_ext && !m_move) return 1'b1;
    if (m_slot < 2) return 1'b1;
    if (m_slot >= 6 && m_slot < 8 && !m_data) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_psen_n();
    if (rst || !m_ext || m_data) return 1'b1;
    if ((m_slot >= 2 && m_slot < 5) || (m_slot >= 8 && m_slot < 11)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string ale_tag();
    if (rst) return "R2";
    if (m_dis && !m_ext && !m_move) return "R8";
    if (m_dis && m_ext) return "R10";
    if (m_dis && m_move) return "R9";
    if (m_data) return "R4";
    return "R3";
  endfunction

  function automatic string psen_tag();
    if (rst) return "R2";
    if (!m_ext) return "R7";
    if (m_data) return "R6";
    return "R5";
  endfunction

  task automatic check_now();
    checks++;
    if (slot !== 4'(m_slot)) begin
      fails++;
      $display("FAIL %sR1 slot actual=%0d expected=%0d", phase, slot, m_slot);
    end
    checks++;
    if (ale !== exp_ale()) begin
      fails++;
      $display("FAIL %s%s ale slot=%0d actual=%b expected=%b",
               phase, ale_tag(), m_slot, ale, exp_ale());
    end
    checks++;
    if (psen_n !== exp_psen_n()) begin
      fails++;
      $display("FAIL %s%s psen_n slot=%0d actual=%b expected=%b",
               phase, psen_tag(), m_slot, psen_n, exp_psen_n());
    end
  endtask

  task automatic set_in(input logic e, input logic d, input logic m, input logic s);
    ext = e; data = d; move = m; dis = s;
  endtask

  // hold inputs constant and check every slot of n machine cycles
  task automatic run_cycles(input int n);
    for (int i = 0; i < n * N; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0b05));
    // R2: reset state, with inputs that would otherwise pulse
    set_in(1, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_now();
    end
    @(negedge clk);
    rst = 1'b0;
    // R3, R5: external fetch, plain cycle
    run_cycles(2);
    // R4, R6: data-memory cycle during external execution
    set_in(1, 1, 0, 0);
    run_cycles(2);
    // R3, R7: internal execution
    set_in(0, 0, 0, 0);
    run_cycles(1);
    // R4, R7
    set_in(0, 1, 0, 0);
    run_cycles(1);
    // R8: disabled, no move, internal
    set_in(0, 0, 0, 1);
    run_cycles(2);
    set_in(0, 1, 0, 1);
    run_cycles(1);
    // R9: disabled during a move instruction
    set_in(0, 1, 1, 1);
    run_cycles(1);
    set_in(0, 0, 1, 1);
    run_cycles(1);
    // R10: disable bit ignored in external execution
    set_in(1, 0, 0, 1);
    run_cycles(1);
    set_in(1, 1, 0, 1);
    run_cycles(1);
    // R11: toggle inputs mid-cycle; the change waits for slot 0
    set_in(1, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      check_now();
      if (i == 3) set_in(0, 1, 0, 1);
    end
    run_cycles(1);
    // R11: random inputs changing on every clock
    phase = "R11/";
    for (int i = 0; i < 300 * N; i++) begin
      @(negedge clk);
      check_now();
      set_in(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    // R1, R2: reset mid-cycle restarts at slot 0
    phase = "";
    set_in(1, 0, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_now();
    end
    rst = 1'b0;
    run_cycles(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule